// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Arbiter

This block collects interrupt requests from a row of sources that share one request line to a processor. Sources are split into priority groups; inside each group an acknowledge travels down a chain and is absorbed by the first stage that is asking for service. Stage 0, nearest the processor, outranks all the others. The winning source puts its vector code on the data bus and its request is removed. The vector is the start address of that source's service routine.

The processor side sees a simple handshake. It watches `intr`, pulses `inta` when it is ready to take a vector, and captures `vec` in the following cycle while `vec_valid` is high. A global enable gates every ordinary source. A separate non-maskable request ignores that enable. An in-service stack records the priority level of each accepted interrupt. Only a strictly higher level can nest on top of the current one, and an end-of-service pulse pops the stack.

Top module: `daisy_irq_arbiter`

## Requirements
- R1: `intr` is high exactly when a non-maskable request is pending and eligible, or when any pending ordinary source is both enabled and eligible. Pending ordinary sources count only while `ien` is high.
- R2: An `inta` pulse is accepted only in a cycle where `intr` is high. In the cycle after an accepted pulse, `vec_valid` is high and `vec` holds the vector. `inta` while `intr` is low changes nothing, and `vec_valid` stays low.
- R3: When requests arrive together, the highest eligible level wins. Inside a group the stage with the lowest index wins. Group g holds source indices g*NPER to g*NPER+NPER-1, and group 0 is the highest ordinary level.
- R4: Source i supplies vector VEC_BASE + VEC_STEP*i. The non-maskable request supplies NMI_VEC.
- R5: The accepted source's pending request is cleared. A new `src_req` pulse for that same source in the acceptance cycle stays pending.
- R6: A request can be accepted only if its level is strictly higher priority than the level now in service. A request held off this way stays pending.
- R7: `eos` pops one stack entry and restores the previous level. It has no effect when the stack is empty, and none in a cycle where an `inta` is accepted.
- R8: With `ien` low, ordinary requests neither raise `intr` nor win, but they stay pending. A non-maskable request is serviced whatever `ien` is.
- R9: `svc_level` encodes the current level as follows: 0 is non-maskable, g+1 is group g, and NGRP+1 is idle. After reset it reads idle, with `intr` and `vec_valid` low.
- R10: The in-service stack never holds more than NGRP+1 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NGRP*NPER | One-cycle request pulse per source |
| nmi | input | 1 | One-cycle non-maskable request pulse |
| ien | input | 1 | Global enable for ordinary sources |
| inta | input | 1 | Interrupt acknowledge from processor |
| eos | input | 1 | End-of-service pulse |
| intr | output | 1 | Shared interrupt request line |
| vec_valid | output | 1 | Vector valid this cycle |
| vec | output | VW | Vector code of accepted source |
| svc_level | output | clog2(NGRP+2) | Level currently in service |

## Verification
Every one of the 255 non-empty request patterns over eight sources is drained one acknowledge at a time. A chain that passed the acknowledge past a requesting stage, or ranked the groups the wrong way round, would hand out vectors out of ascending index order. Between drains the bench checks that `intr` stays low while equal or lower levels are in service; a nesting test that used "lower or equal" would let a same-level request break in. Directed cases cover the rest. They mask ordinary requests while a non-maskable one still gets through, and fill the stack to its full depth. They pop an empty stack, and raise a request on the very cycle it is being acknowledged, which a design that let the clear win would lose. They also send an `eos` together with an accepted acknowledge, where a design that let the pop win would leave the level wrong.

// File: rtl/daisy_irq_arbiter.sv
`timescale 1ns/1ps
module daisy_irq_arbiter #(
  parameter int NGRP = 2,
  parameter int NPER = 4,
  parameter int VW = 8,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 4,
  parameter int NMI_VEC = 'h08,
  localparam int N = NGRP * NPER,
  localparam int LW = $clog2(NGRP + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_req,
  input  logic          nmi,
  input  logic          ien,
  input  logic          inta,
  input  logic          eos,
  output logic          intr,
  output logic          vec_valid,
  output logic [VW-1:0] vec,
  output logic [LW-1:0] svc_level
);
  localparam int DEPTH = NGRP + 1;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] IDLE = LW'(NGRP + 1);

  logic [N-1:0]    pend, win;
  logic            nmi_pend, nmi_ok, accept;
  logic [NGRP-1:0] grp_any, blk;
  logic [LW-1:0]   stk [DEPTH];
  logic [SPW-1:0]  sp;
  logic [LW-1:0]   cur, acc_lvl;
  logic [VW-1:0]   acc_vec;

  always_comb begin
    cur = IDLE;
    for (int k = 0; k < DEPTH; k++)
      if (SPW'(k + 1) == sp) cur = stk[k];
  end

  assign nmi_ok = nmi_pend && (cur != '0);
  assign intr   = nmi_ok || (|grp_any);
  assign accept = inta && intr;
  assign blk[0] = 1'b0;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [NPER-1:0] ack;
    assign grp_any[g] = ien && (LW'(g + 1) < cur) && (|pend[g*NPER +: NPER]);
    assign ack[0] = accept && !nmi_ok && !blk[g] && grp_any[g];
    if (g < NGRP - 1) begin : g_blk
      assign blk[g+1] = blk[g] || grp_any[g];
    end
    for (genvar i = 0; i < NPER; i++) begin : g_stage
      assign win[g*NPER+i] = ack[i] && pend[g*NPER+i];
      if (i < NPER - 1) begin : g_pass
        assign ack[i+1] = ack[i] && !pend[g*NPER+i];
      end
    end
  end

  always_comb begin
    acc_lvl = IDLE;
    acc_vec = VW'(NMI_VEC);
    for (int g = NGRP - 1; g >= 0; g--)
      if (grp_any[g]) acc_lvl = LW'(g + 1);
    for (int i = 0; i < N; i++)
      if (win[i]) acc_vec = VW'(VEC_BASE + VEC_STEP * i);
    if (nmi_ok) begin
      acc_lvl = '0;
      acc_vec = VW'(NMI_VEC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      nmi_pend  <= 1'b0;
      sp        <= '0;
      vec_valid <= 1'b0;
      vec       <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= IDLE;
    end else begin
      pend      <= (pend & ~win) | src_req;
      nmi_pend  <= (nmi_pend && !(accept && nmi_ok)) || nmi;
      vec_valid <= accept;
      if (accept) begin
        vec <= acc_vec;
        for (int k = 0; k < DEPTH; k++)
          if (SPW'(k) == sp) stk[k] <= acc_lvl;
        sp <= sp + 1'b1;
      end else if (eos && sp != '0) begin
        sp <= sp - 1'b1;
      end
    end
  end

  assign svc_level = cur;
endmodule

module daisy_irq_arbiter_chk #(
  parameter int NGRP = 2,
  parameter int LW = 2,
  parameter int SPW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           inta,
  input logic           eos,
  input logic           intr,
  input logic           vec_valid,
  input logic [LW-1:0]  svc_level,
  input logic [SPW-1:0] sp
);
  localparam logic [LW-1:0] IDLE = LW'(NGRP + 1);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp) <= NGRP + 1);
  a_r2_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta && intr));
  a_r2_ignored_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !intr) |=> !vec_valid);
  a_r6_nest_higher: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> svc_level < $past(svc_level));
  a_r7_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !(inta && intr) && svc_level != IDLE) |=> svc_level > $past(svc_level));
endmodule

bind daisy_irq_arbiter daisy_irq_arbiter_chk #(.NGRP(NGRP), .LW(LW), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .eos(eos), .intr(intr),
  .vec_valid(vec_valid), .svc_level(svc_level), .sp(sp)
);

// File: tb/daisy_irq_arbiter_test.sv
`timescale 1ns/1ps
module daisy_irq_arbiter_test;
  logic clk = 0, rst_n = 0, nmi = 0, ien = 1, inta = 0, eos = 0;
  logic [7:0] src_req = '0;
  logic intr, vec_valid;
  logic [7:0] vec;
  logic [1:0] svc_level;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  daisy_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .nmi(nmi), .ien(ien),
    .inta(inta), .eos(eos), .intr(intr), .vec_valid(vec_valid), .vec(vec),
    .svc_level(svc_level)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; src_req = '0; nmi = 0; ien = 1; inta = 0; eos = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic raise(input logic [7:0] m);
    src_req = m; step(); src_req = '0;
  endtask

  task automatic ack_expect(input string req, input int v, input int lvl);
    inta = 1; step(); inta = 0;
    check({req, " vec_valid"}, vec_valid, 1);
    check({req, " vec"}, vec, v);
    check({req, " level"}, svc_level, lvl);
    step();
    check({req, " vec_valid drop"}, vec_valid, 0);
  endtask

  task automatic pop();
    eos = 1; step(); eos = 0;
  endtask

  initial begin
    do_reset();
    check("R9 reset intr", intr, 0);
    check("R9 reset vec_valid", vec_valid, 0);
    check("R9 reset level", svc_level, 3);

    inta = 1; step(); inta = 0;
    check("R2 spurious ack vec_valid", vec_valid, 0);
    check("R2 spurious ack level", svc_level, 3);

    for (int p = 1; p < 256; p++) begin
      logic [7:0] rem;
      do_reset();
      rem = 8'(p);
      raise(rem);
      check("R1 intr on request", intr, 1);
      while (rem != 0) begin
        int w;
        w = 0;
        for (int k = 7; k >= 0; k--) if (rem[k]) w = k;
        ack_expect("R3 R4 chain order", 'h40 + 4 * w, w / 4 + 1);
        rem[w] = 1'b0;
        check("R6 no equal or lower nest", intr, 0);
        pop();
        check("R7 pop to idle", svc_level, 3);
        check("R1 intr after pop", intr, (rem != 0) ? 1 : 0);
      end
    end

    do_reset();
    raise(8'h20);
    ack_expect("R6 base group1", 'h54, 2);
    raise(8'h40);
    check("R6 same level held off", intr, 0);
    raise(8'h02);
    check("R6 higher level nests", intr, 1);
    ack_expect("R6 nested", 'h44, 1);
    pop();
    check("R7 restore level", svc_level, 2);
    check("R6 held request still off", intr, 0);
    pop();
    check("R7 idle", svc_level, 3);
    check("R6 held request now up", intr, 1);
    ack_expect("R6 held request served", 'h58, 2);
    pop();

    do_reset();
    ien = 0;
    raise(8'h04);
    check("R8 masked intr", intr, 0);
    inta = 1; step(); inta = 0;
    check("R8 masked ack ignored", vec_valid, 0);
    check("R8 masked level", svc_level, 3);
    nmi = 1; step(); nmi = 0;
    check("R8 nmi bypasses mask", intr, 1);
    ack_expect("R4 R8 nmi vector", 'h08, 0);
    pop();
    check("R8 still masked", intr, 0);
    ien = 1; step();
    check("R8 pending kept", intr, 1);
    ack_expect("R8 unmasked served", 'h48, 1);
    pop();

    do_reset();
    raise(8'h10);
    ack_expect("R10 depth1", 'h50, 2);
    raise(8'h01);
    ack_expect("R10 depth2", 'h40, 1);
    nmi = 1; step(); nmi = 0;
    check("R1 nmi nests", intr, 1);
    ack_expect("R10 depth3", 'h08, 0);
    nmi = 1; step(); nmi = 0;
    check("R6 nmi over nmi held", intr, 0);
    pop();
    check("R7 pop1", svc_level, 1);
    ack_expect("R6 second nmi after pop", 'h08, 0);
    pop(); pop();
    check("R7 pop2", svc_level, 2);
    pop();
    check("R7 pop3", svc_level, 3);
    pop();
    check("R7 empty pop", svc_level, 3);
    raise(8'h08);
    ack_expect("R7 after empty pop", 'h4C, 1);
    pop();

    do_reset();
    raise(8'h02);
    src_req = 8'h02; inta = 1; step(); inta = 0; src_req = '0;
    check("R5 vec", vec, 'h44);
    check("R5 held same level", intr, 0);
    step();
    pop();
    check("R5 request kept", intr, 1);
    ack_expect("R5 re-served", 'h44, 1);
    pop();

    do_reset();
    raise(8'h20);
    inta = 1; eos = 1; step(); inta = 0; eos = 0;
    check("R7 eos with accept ignored", svc_level, 2);
    pop();
    check("R7 later pop", svc_level, 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule